// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block follows the state of a single SDRAM bank from the command bus. On every rising clock edge it samples the four registered command strobes, a flag that says whether the addressed bank is this one, and the auto-precharge address bit. It then moves through the bank's life cycle: idle, opening a row, row open, read burst, write burst, the two self-closing burst states, and closing. A memory controller can use it to find out which commands it may issue next. A bus monitor can use it to flag protocol violations.

Each command is checked against the set of commands allowed in the current state. An illegal command produces a one-cycle error pulse. The bank then carries on as if a no-operation had been issued. The row-to-column delay, the precharge delay and the burst length are parameters, counted in clock cycles by one shared down-counter.

Top module: `sdr_bank_tracker`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `bank_state` reads 0 (idle) and `cmd_err` reads 0.
- R2: The strobes are read as {cs_n,ras_n,cas_n,we_n}, with cs_n = 0 for every command except inhibit. The codes are: 0111 no-op, 0011 activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge, 0001 refresh, 0000 mode load. Refresh and mode load act on this bank whatever `bank_hit` is. Precharge acts on this bank when `bank_hit` or `auto_pre` is 1, where `auto_pre` = 1 means all banks. Activate, read, write and burst stop need `bank_hit`.
- R3: An activate in idle moves the bank to state 1 (opening). It stays there for T_RCD cycles and then reaches state 2 (row open).
- R4: In idle the allowed commands are activate, refresh, mode load and precharge. Refresh and mode load leave the bank idle. Precharge moves it to state 7 (closing). A read, write or burst stop in idle is an error.
- R5: In row open, a read with `auto_pre` = 0 moves the bank to state 3, and a write with `auto_pre` = 0 moves it to state 4. After BURST_LEN cycles with no new command, the bank goes back to state 2.
- R6: During state 3 or 4, a new read or write restarts the burst count and picks the state that matches the new command. Burst stop returns the bank to state 2. Precharge cuts the burst short and moves the bank to state 7.
- R7: A read or write with `auto_pre` = 1 issued in row open moves the bank to state 5 (read) or state 6 (write). The bank stays there for BURST_LEN + T_RP cycles and then goes to idle.
- R8: State 7 lasts T_RP cycles and then the bank returns to idle.
- R9: States 1, 5, 6 and 7 cannot be interrupted. Any command that acts on this bank while it is in one of them is an error.
- R10: In row open and in the two plain burst states, activate, refresh and mode load are errors. Burst stop is also an error in row open.
- R11: An illegal command drives `cmd_err` high for exactly the cycle after the edge that sampled it. The state and timing then continue as for a no-operation. Inhibit, no-op, and bank commands with `bank_hit` = 0 never cause an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Registered chip-select strobe |
| ras_n | input | 1 | Registered row strobe |
| cas_n | input | 1 | Registered column strobe |
| we_n | input | 1 | Registered write-enable strobe |
| bank_hit | input | 1 | The bank address of this command selects this bank |
| auto_pre | input | 1 | Auto-precharge on read/write; all-bank select on precharge |
| bank_state | output | 3 | Current bank state, codes 0 to 7 as listed in the requirements |
| cmd_err | output | 1 | One-cycle pulse for an illegal command |

## Verification
The properties assume that the strobes, `bank_hit` and `auto_pre` are settled at every rising edge and carry a known value. They do not assume that the command stream is legal, because flagging illegal commands is the block's job. The stimulus changes inputs only on falling edges and drives only 0 or 1. It deliberately mixes legal sequences with commands aimed at busy states, commands aimed at other banks, and all-bank precharge, so that the error path and the ignore path are both exercised under the same input rules.

// File: rtl/sdr_bank_pkg.sv
package sdr_bank_pkg;

   // Bank life-cycle states; codes are visible on the bank_state port.
   typedef enum logic [2:0] {
      BK_IDLE    = 3'd0,
      BK_OPENING = 3'd1,
      BK_OPEN    = 3'd2,
      BK_RD      = 3'd3,
      BK_WR      = 3'd4,
      BK_RD_AP   = 3'd5,
      BK_WR_AP   = 3'd6,
      BK_CLOSING = 3'd7
   } bank_st_t;

   // Command after bank qualification; OP_NONE covers no-op, inhibit
   // and commands for another bank.
   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_ACT  = 3'd1,
      OP_RD   = 3'd2,
      OP_WR   = 3'd3,
      OP_BST  = 3'd4,
      OP_PRE  = 3'd5,
      OP_REF  = 3'd6,
      OP_LMR  = 3'd7
   } bank_op_t;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
   import sdr_bank_pkg::*;
(
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   input  logic     bank_hit,
   input  logic     auto_pre,
   output bank_op_t op
);

   always_comb begin
      op = OP_NONE;
      if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  op = bank_hit ? OP_ACT : OP_NONE;
            3'b101:  op = bank_hit ? OP_RD  : OP_NONE;
            3'b100:  op = bank_hit ? OP_WR  : OP_NONE;
            3'b110:  op = bank_hit ? OP_BST : OP_NONE;
            3'b010:  op = (bank_hit || auto_pre) ? OP_PRE : OP_NONE;
            3'b001:  op = OP_REF;
            3'b000:  op = OP_LMR;
            default: op = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sdr_legal_check.sv
module sdr_legal_check
   import sdr_bank_pkg::*;
(
   input  bank_st_t st,
   input  bank_op_t op,
   output logic     legal
);

   always_comb begin
      legal = 1'b0;
      if (op == OP_NONE) begin
         legal = 1'b1;
      end else begin
         case (st)
            BK_IDLE:
               legal = (op == OP_ACT) || (op == OP_REF) ||
                       (op == OP_LMR) || (op == OP_PRE);
            BK_OPEN:
               legal = (op == OP_RD) || (op == OP_WR) || (op == OP_PRE);
            BK_RD, BK_WR:
               legal = (op == OP_RD) || (op == OP_WR) ||
                       (op == OP_PRE) || (op == OP_BST);
            default:
               legal = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/sdr_bank_timer.sv
module sdr_bank_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
   import sdr_bank_pkg::*;
#(
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int BURST_LEN = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   input  logic       bank_hit,
   input  logic       auto_pre,
   output logic [2:0] bank_state,
   output logic       cmd_err
);

   localparam int AP_SPAN = BURST_LEN + T_RP;
   localparam int MAXV0   = (T_RCD > AP_SPAN) ? T_RCD : AP_SPAN;
   localparam int CW      = $clog2(MAXV0) + 1;

   localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
   localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
   localparam logic [CW-1:0] LD_BL  = CW'(BURST_LEN - 1);
   localparam logic [CW-1:0] LD_AP  = CW'(AP_SPAN - 1);

   generate
      if (T_RCD < 1) begin : g_bad_rcd
         $error("T_RCD must be at least 1");
      end
      if (T_RP < 1) begin : g_bad_rp
         $error("T_RP must be at least 1");
      end
      if (BURST_LEN < 1) begin : g_bad_bl
         $error("BURST_LEN must be at least 1");
      end
   endgenerate

   bank_op_t      op;
   bank_op_t      eff_op;
   logic          legal;
   logic          t_zero;
   logic          t_load;
   logic [CW-1:0] t_val;
   bank_st_t      st_q, st_d;
   logic          err_q;

   sdr_cmd_decode u_dec (
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .bank_hit (bank_hit),
      .auto_pre (auto_pre),
      .op       (op)
   );

   sdr_legal_check u_legal (
      .st    (st_q),
      .op    (op),
      .legal (legal)
   );

   sdr_bank_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   // An illegal command is handled as a no-operation.
   assign eff_op = legal ? op : OP_NONE;

   always_comb begin
      st_d   = st_q;
      t_load = 1'b0;
      t_val  = '0;
      case (st_q)
         BK_IDLE: begin
            if (eff_op == OP_ACT) begin
               st_d = BK_OPENING; t_load = 1'b1; t_val = LD_RCD;
            end else if (eff_op == OP_PRE) begin
               st_d = BK_CLOSING; t_load = 1'b1; t_val = LD_RP;
            end
         end
         BK_OPENING: begin
            if (t_zero) st_d = BK_OPEN;
         end
         BK_OPEN, BK_RD, BK_WR: begin
            if (eff_op == OP_RD || eff_op == OP_WR) begin
               t_load = 1'b1;
               if (auto_pre) begin
                  st_d  = (eff_op == OP_RD) ? BK_RD_AP : BK_WR_AP;
                  t_val = LD_AP;
               end else begin
                  st_d  = (eff_op == OP_RD) ? BK_RD : BK_WR;
                  t_val = LD_BL;
               end
            end else if (eff_op == OP_PRE) begin
               st_d = BK_CLOSING; t_load = 1'b1; t_val = LD_RP;
            end else if (eff_op == OP_BST) begin
               st_d = BK_OPEN;
            end else if (st_q != BK_OPEN && t_zero) begin
               st_d = BK_OPEN;
            end
         end
         default: begin
            if (t_zero) st_d = BK_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= BK_IDLE;
         err_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         err_q <= !legal;
      end
   end

   assign bank_state = st_q;
   assign cmd_err    = err_q;

endmodule

// File: rtl/sdr_bank_tracker_chk.sv
module sdr_bank_tracker_chk
   import sdr_bank_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       ras_n,
   input logic       cas_n,
   input logic       we_n,
   input logic       bank_hit,
   input logic       bank_state_q_unused,
   input logic [2:0] bank_state,
   input logic       cmd_err
);

   logic act_here;
   assign act_here = !cs_n && !ras_n && cas_n && we_n && bank_hit;

   // R1: reset value
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (bank_state == 3'd0 && !cmd_err);
      end
   end

   // R3: activate from idle opens the row without error
   assert_idle_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state == 3'd0 && act_here) |=> (bank_state == 3'd1 && !cmd_err));

   // R3: opening only ever leads to row open
   assert_opening_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state == 3'd1) |=> (bank_state == 3'd1 || bank_state == 3'd2));

   // R7: self-closing bursts end in idle only
   assert_ap_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state == 3'd5 || bank_state == 3'd6) |=>
      (bank_state == $past(bank_state) || bank_state == 3'd0));

   // R8: closing ends in idle only
   assert_closing_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state == 3'd7) |=> (bank_state == 3'd7 || bank_state == 3'd0));

   // R10: activate to an open row is flagged and changes nothing
   assert_open_act_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state == 3'd2 && act_here) |=> (cmd_err && bank_state == 3'd2));

   // R11: inhibit is never an error
   assert_inhibit_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !cmd_err);

endmodule

bind sdr_bank_tracker sdr_bank_tracker_chk u_chk (
   .clk                 (clk),
   .rst_n               (rst_n),
   .cs_n                (cs_n),
   .ras_n               (ras_n),
   .cas_n               (cas_n),
   .we_n                (we_n),
   .bank_hit            (bank_hit),
   .bank_state_q_unused (1'b0),
   .bank_state          (bank_state),
   .cmd_err             (cmd_err)
);

// File: tb/sim_sdr_bank_tracker.sv
module sim_sdr_bank_tracker;

   localparam int NV = 55;

   // strobe codes {cs_n,ras_n,cas_n,we_n}
   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_ACT = 4'b0011;
   localparam logic [3:0] C_RD  = 4'b0101;
   localparam logic [3:0] C_WR  = 4'b0100;
   localparam logic [3:0] C_BST = 4'b0110;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_LMR = 4'b0000;
   localparam logic [3:0] C_INH = 4'b1000;

   // {req, strobes, bank_hit, auto_pre, expected state, expected err}
   // bench timing: T_RCD=2, T_RP=2, BURST_LEN=2
   localparam logic [13:0] VEC [0:NV-1] = '{
      {4'd11, C_NOP, 2'b10, 3'd0, 1'b0},
      {4'd4,  C_RD,  2'b10, 3'd0, 1'b1},
      {4'd3,  C_ACT, 2'b10, 3'd1, 1'b0},
      {4'd3,  C_NOP, 2'b10, 3'd1, 1'b0},
      {4'd3,  C_NOP, 2'b10, 3'd2, 1'b0},
      {4'd5,  C_RD,  2'b10, 3'd3, 1'b0},
      {4'd5,  C_NOP, 2'b10, 3'd3, 1'b0},
      {4'd5,  C_NOP, 2'b10, 3'd2, 1'b0},
      {4'd5,  C_WR,  2'b10, 3'd4, 1'b0},
      {4'd6,  C_WR,  2'b10, 3'd4, 1'b0},
      {4'd6,  C_NOP, 2'b10, 3'd4, 1'b0},
      {4'd6,  C_RD,  2'b10, 3'd3, 1'b0},
      {4'd6,  C_BST, 2'b10, 3'd2, 1'b0},
      {4'd10, C_BST, 2'b10, 3'd2, 1'b1},
      {4'd10, C_ACT, 2'b10, 3'd2, 1'b1},
      {4'd8,  C_PRE, 2'b10, 3'd7, 1'b0},
      {4'd9,  C_ACT, 2'b10, 3'd7, 1'b1},
      {4'd8,  C_NOP, 2'b10, 3'd0, 1'b0},
      {4'd3,  C_ACT, 2'b10, 3'd1, 1'b0},
      {4'd3,  C_NOP, 2'b10, 3'd1, 1'b0},
      {4'd3,  C_NOP, 2'b10, 3'd2, 1'b0},
      {4'd7,  C_RD,  2'b11, 3'd5, 1'b0},
      {4'd7,  C_NOP, 2'b10, 3'd5, 1'b0},
      {4'd9,  C_RD,  2'b10, 3'd5, 1'b1},
      {4'd7,  C_NOP, 2'b10, 3'd5, 1'b0},
      {4'd7,  C_NOP, 2'b10, 3'd0, 1'b0},
      {4'd4,  C_REF, 2'b10, 3'd0, 1'b0},
      {4'd4,  C_LMR, 2'b10, 3'd0, 1'b0},
      {4'd2,  C_ACT, 2'b00, 3'd0, 1'b0},
      {4'd11, C_INH, 2'b10, 3'd0, 1'b0},
      {4'd3,  C_ACT, 2'b10, 3'd1, 1'b0},
      {4'd3,  C_NOP, 2'b10, 3'd1, 1'b0},
      {4'd3,  C_NOP, 2'b10, 3'd2, 1'b0},
      {4'd7,  C_WR,  2'b11, 3'd6, 1'b0},
      {4'd7,  C_NOP, 2'b10, 3'd6, 1'b0},
      {4'd7,  C_NOP, 2'b10, 3'd6, 1'b0},
      {4'd7,  C_NOP, 2'b10, 3'd6, 1'b0},
      {4'd7,  C_NOP, 2'b10, 3'd0, 1'b0},
      {4'd3,  C_ACT, 2'b10, 3'd1, 1'b0},
      {4'd3,  C_NOP, 2'b10, 3'd1, 1'b0},
      {4'd3,  C_NOP, 2'b10, 3'd2, 1'b0},
      {4'd5,  C_RD,  2'b10, 3'd3, 1'b0},
      {4'd2,  C_PRE, 2'b01, 3'd7, 1'b0},
      {4'd8,  C_NOP, 2'b10, 3'd7, 1'b0},
      {4'd8,  C_NOP, 2'b10, 3'd0, 1'b0},
      {4'd4,  C_PRE, 2'b10, 3'd7, 1'b0},
      {4'd9,  C_REF, 2'b00, 3'd7, 1'b1},
      {4'd8,  C_NOP, 2'b10, 3'd0, 1'b0},
      {4'd3,  C_ACT, 2'b10, 3'd1, 1'b0},
      {4'd3,  C_NOP, 2'b10, 3'd1, 1'b0},
      {4'd3,  C_NOP, 2'b10, 3'd2, 1'b0},
      {4'd2,  C_REF, 2'b00, 3'd2, 1'b1},
      {4'd11, C_RD,  2'b00, 3'd2, 1'b0},
      {4'd2,  C_PRE, 2'b00, 3'd2, 1'b0},
      {4'd11, C_WR,  2'b01, 3'd2, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] strobes = 4'b1111;
   logic       bank_hit = 1'b0;
   logic       auto_pre = 1'b0;
   logic [2:0] bank_state;
   logic       cmd_err;
   int         n_chk = 0;
   int         n_fail = 0;

   always #2 clk = ~clk;

   sdr_bank_tracker #(.T_RCD(2), .T_RP(2), .BURST_LEN(2)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (strobes[3]),
      .ras_n      (strobes[2]),
      .cas_n      (strobes[1]),
      .we_n       (strobes[0]),
      .bank_hit   (bank_hit),
      .auto_pre   (auto_pre),
      .bank_state (bank_state),
      .cmd_err    (cmd_err)
   );

   function automatic string rtag(input int n);
      case (n)
         1:  return "R1";
         2:  return "R2";
         3:  return "R3";
         4:  return "R4";
         5:  return "R5";
         6:  return "R6";
         7:  return "R7";
         8:  return "R8";
         9:  return "R9";
         10: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string req, input logic [2:0] est, input logic eerr);
      n_chk++;
      if (bank_state !== est || cmd_err !== eerr) begin
         n_fail++;
         $display("FAIL %s: state=%0d err=%0b, expected state=%0d err=%0b",
                  req, bank_state, cmd_err, est, eerr);
      end
   endtask

   task automatic drive(input logic [3:0] s, input logic h, input logic a);
      strobes  = s;
      bank_hit = h;
      auto_pre = a;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 3'd0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 3'd0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][9:6], VEC[i][5], VEC[i][4]);
         check(rtag(int'(VEC[i][13:10])), VEC[i][3:1], VEC[i][0]);
      end

      // R11: error pulse lasts one cycle
      drive(C_BST, 1'b1, 1'b0);
      check("R11", 3'd2, 1'b1);
      drive(C_NOP, 1'b1, 1'b0);
      check("R11", 3'd2, 1'b0);

      // R1: reset in the middle of a burst
      drive(C_WR, 1'b1, 1'b0);
      check("R5", 3'd4, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", 3'd0, 1'b0);
      rst_n = 1'b1;
      drive(C_NOP, 1'b1, 1'b0);
      check("R1", 3'd0, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule